// File: doc/BRIEF.md
# Machine-Mode Control Register and Timer Unit

This unit holds the machine-level control state of a small 32-bit processor core and serves the core's control-register access instructions. The core presents one access per cycle: a 12-bit register index, an operation (write, bit-set, bit-clear or plain read) and an operand. The unit returns the old value of the selected register one cycle later, applies the operation, and flags any index it does not implement. Only a handful of indices in the 4096-entry space exist: global status, interrupt enable, interrupt pending, trap vector, exception return address and trap cause, three 64-bit counters (clock cycles, wall-clock time, retired instructions) and a 64-bit timer compare value.

The compare value sits in the register space as two 32-bit halves, so the timer can be programmed with ordinary register accesses and no bus transaction is needed. When the time counter reaches the compare value the timer becomes pending, and when local and global enables are also on, a timer interrupt request goes out to the core. The core signals trap entry with the interrupted PC and a cause code, and trap return with a single pulse. The unit saves and restores the global enable and drives the handler address and the return PC straight from its registers.

Top module: `mcsr_unit`

## Requirements
- R1: After synchronous reset, csr_rdata, csr_illegal, irq_timer, handler_addr and return_pc are 0, the status register reads 0x1800, and both compare halves (0x800, 0x801) read 0xFFFFFFFF.
- R2: csr_rdata and csr_illegal are registered: they show the result of an access in the cycle after csr_en is high, and csr_rdata holds the register value from before any update that same access makes.
- R3: csr_op encodes 0 = write, 1 = set bits of csr_wdata, 2 = clear bits of csr_wdata, 3 = read only; the new value is visible to the next access, and op 3 never changes a register.
- R4: The 64-bit time counter (low half 0xC01, high half 0xC81) increments by one in each clock with time_tick high and holds otherwise.
- R5: The 64-bit cycle counter (low 0xC00, high 0xC80) increments by one in every clock after reset.
- R6: The 64-bit retired counter (low 0xC02, high 0xC82) increments by one in each clock with instret high.
- R7: The 64-bit compare value is written through 0x800 (low) and 0x801 (high); bit 7 of the pending register 0x344 becomes 1 one clock after the time counter is greater than or equal to the compare value, and 0 one clock after it is not.
- R8: irq_timer is 1 one clock after pending bit 7, enable bit 7 of 0x304 and global-enable bit 3 of 0x300 are all 1, and 0 one clock after any of them is 0.
- R9: On trap_take, the next cycle has return address 0x341 = trap_pc with bits 1:0 cleared, cause 0x342 = trap_cause, status bit 7 = previous bit 3, and status bit 3 = 0; trap_take wins over a same-cycle register write to those registers.
- R10: On trap_ret (without trap_take), status bit 3 takes the value of status bit 7, and bit 7 becomes 1.
- R11: The trap vector 0x305 and return address 0x341 keep bits 1:0 at zero on write; handler_addr and return_pc always equal them, and the cause register 0x342 is fully writable.
- R12: An access to an unimplemented index returns 0 with csr_illegal = 1; writes to the counters and to the pending register are ignored and do not raise csr_illegal.
- R13: In the status register only bits 3 and 7 are writable; bits 12:11 read as 1 and all other bits read 0. In the enable register only bit 7 is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_op | input | 2 | Operation: 0 write, 1 set, 2 clear, 3 read |
| csr_addr | input | 12 | Register index |
| csr_wdata | input | 32 | Write operand or bit mask |
| csr_rdata | output | 32 | Old value of the accessed register |
| csr_illegal | output | 1 | Accessed index is not implemented |
| time_tick | input | 1 | Advance the wall-clock time counter |
| instret | input | 1 | One instruction retired |
| trap_take | input | 1 | Enter a trap this cycle |
| trap_pc | input | 32 | PC saved on trap entry |
| trap_cause | input | 32 | Cause code saved on trap entry |
| trap_ret | input | 1 | Return from trap handler |
| handler_addr | output | 32 | Trap handler address |
| return_pc | output | 32 | Saved return address |
| irq_timer | output | 1 | Timer interrupt request |

## Verification
Read data and the illegal flag are due one clock after the access, register updates from an access or a trap are visible to the access that follows, pending follows the time/compare relation one clock late, and irq_timer follows pending and the enables one clock after that, so a timer crossing shows up two clocks after the tick that caused it. The bench drives every stimulus on the falling edge, holds it across exactly one rising edge, and samples on the next falling edge; for the timer path it waits three idle clocks before looking at irq_timer, and for counters it compares two reads a known number of rising edges apart. Cases where the interrupt must stay off are checked with the same waits so a late assertion would still be seen.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int XLEN   = 32;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 2 * XLEN;
  localparam int NCNT   = 3;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_READ  = 2'd3
  } csr_op_e;

  localparam logic [ADDR_W-1:0] IDX_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] IDX_ENABLE  = 12'h304;
  localparam logic [ADDR_W-1:0] IDX_VECTOR  = 12'h305;
  localparam logic [ADDR_W-1:0] IDX_RETPC   = 12'h341;
  localparam logic [ADDR_W-1:0] IDX_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] IDX_PENDING = 12'h344;
  localparam logic [ADDR_W-1:0] IDX_CMP_LO  = 12'h800;
  localparam logic [ADDR_W-1:0] IDX_CMP_HI  = 12'h801;

  localparam int GIE_BIT   = 3;
  localparam int GPIE_BIT  = 7;
  localparam int TIMER_BIT = 7;

  function automatic logic [XLEN-1:0] csr_apply(csr_op_e op,
                                                logic [XLEN-1:0] old_v,
                                                logic [XLEN-1:0] opnd);
    case (op)
      OP_WRITE: return opnd;
      OP_SET:   return old_v | opnd;
      OP_CLEAR: return old_v & ~opnd;
      default:  return old_v;
    endcase
  endfunction

endpackage

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/mcsr_timer.sv
module mcsr_timer #(
  parameter int XLEN = 32,
  parameter int W    = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    now,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wval,
  output logic [W-1:0]    cmp,
  output logic            pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp     <= '1;
      pending <= 1'b0;
    end else begin
      if (wr_lo) cmp[XLEN-1:0] <= wval;
      if (wr_hi) cmp[W-1:XLEN] <= wval;
      pending <= (now >= cmp);
    end
  end
endmodule

// File: rtl/mcsr_trap.sv
module mcsr_trap
  import mcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [XLEN-1:0]   wval,
  input  logic              trap_take,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_cause,
  input  logic              trap_ret,
  output logic              gie,
  output logic              gpie,
  output logic              tie,
  output logic [XLEN-1:0]   vector,
  output logic [XLEN-1:0]   retpc,
  output logic [XLEN-1:0]   cause
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(3));

  logic wr_status, wr_enable, wr_vector, wr_retpc, wr_cause;

  always_comb begin
    wr_status = wr_fire && (wr_addr == IDX_STATUS);
    wr_enable = wr_fire && (wr_addr == IDX_ENABLE);
    wr_vector = wr_fire && (wr_addr == IDX_VECTOR);
    wr_retpc  = wr_fire && (wr_addr == IDX_RETPC);
    wr_cause  = wr_fire && (wr_addr == IDX_CAUSE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie    <= 1'b0;
      gpie   <= 1'b0;
      tie    <= 1'b0;
      vector <= '0;
      retpc  <= '0;
      cause  <= '0;
    end else begin
      if (wr_enable) tie    <= wval[TIMER_BIT];
      if (wr_vector) vector <= wval & ALIGN_MASK;
      if (trap_take) begin
        retpc <= trap_pc & ALIGN_MASK;
        cause <= trap_cause;
        gpie  <= gie;
        gie   <= 1'b0;
      end else begin
        if (wr_retpc) retpc <= wval & ALIGN_MASK;
        if (wr_cause) cause <= wval;
        if (trap_ret) begin
          gie  <= gpie;
          gpie <= 1'b1;
        end else if (wr_status) begin
          gie  <= wval[GIE_BIT];
          gpie <= wval[GPIE_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_en,
  input  logic [1:0]        csr_op,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              time_tick,
  input  logic              instret,
  input  logic              trap_take,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_cause,
  input  logic              trap_ret,
  output logic [XLEN-1:0]   handler_addr,
  output logic [XLEN-1:0]   return_pc,
  output logic              irq_timer
);
  // counter slot k lives at 0xC00+k (low) and 0xC80+k (high)
  localparam int SLOT_CYCLE = 0;
  localparam int SLOT_TIME  = 1;
  localparam int SLOT_RET   = 2;

  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt [NCNT];

  always_comb begin
    cnt_inc             = '0;
    cnt_inc[SLOT_CYCLE] = 1'b1;
    cnt_inc[SLOT_TIME]  = time_tick;
    cnt_inc[SLOT_RET]   = instret;
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    mcsr_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[k]),
      .count (cnt[k])
    );
  end

  csr_op_e          op;
  logic [XLEN-1:0]  rd_val;
  logic             hit;
  logic [XLEN-1:0]  wr_val;
  logic             wr_fire;
  logic             gie, gpie, tie, pending;
  logic [XLEN-1:0]  vector, retpc, cause;
  logic [CNT_W-1:0] cmp;
  logic [1:0]       slot;

  assign op   = csr_op_e'(csr_op);
  assign slot = csr_addr[1:0];

  always_comb begin
    rd_val = '0;
    hit    = 1'b1;
    if (csr_addr[ADDR_W-1:8] == 4'hC && csr_addr[6:2] == 5'd0 &&
        int'(slot) < NCNT) begin
      rd_val = csr_addr[7] ? cnt[slot][CNT_W-1:XLEN] : cnt[slot][XLEN-1:0];
    end else begin
      case (csr_addr)
        IDX_STATUS: begin
          rd_val[12:11]    = 2'b11;
          rd_val[GPIE_BIT] = gpie;
          rd_val[GIE_BIT]  = gie;
        end
        IDX_ENABLE:  rd_val[TIMER_BIT] = tie;
        IDX_PENDING: rd_val[TIMER_BIT] = pending;
        IDX_VECTOR:  rd_val = vector;
        IDX_RETPC:   rd_val = retpc;
        IDX_CAUSE:   rd_val = cause;
        IDX_CMP_LO:  rd_val = cmp[XLEN-1:0];
        IDX_CMP_HI:  rd_val = cmp[CNT_W-1:XLEN];
        default:     hit = 1'b0;
      endcase
    end
  end

  assign wr_val  = csr_apply(op, rd_val, csr_wdata);
  assign wr_fire = csr_en && hit && (op != OP_READ);

  mcsr_timer #(.XLEN(XLEN), .W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .now     (cnt[SLOT_TIME]),
    .wr_lo   (wr_fire && csr_addr == IDX_CMP_LO),
    .wr_hi   (wr_fire && csr_addr == IDX_CMP_HI),
    .wval    (wr_val),
    .cmp     (cmp),
    .pending (pending)
  );

  mcsr_trap u_trap (
    .clk        (clk),
    .rst        (rst),
    .wr_fire    (wr_fire),
    .wr_addr    (csr_addr),
    .wval       (wr_val),
    .trap_take  (trap_take),
    .trap_pc    (trap_pc),
    .trap_cause (trap_cause),
    .trap_ret   (trap_ret),
    .gie        (gie),
    .gpie       (gpie),
    .tie        (tie),
    .vector     (vector),
    .retpc      (retpc),
    .cause      (cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata   <= '0;
      csr_illegal <= 1'b0;
      irq_timer   <= 1'b0;
    end else begin
      csr_illegal <= csr_en && !hit;
      if (csr_en) csr_rdata <= rd_val;
      irq_timer   <= pending && tie && gie;
    end
  end

  assign handler_addr = vector;
  assign return_pc    = retpc;

endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk
  import mcsr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             trap_take,
  input logic             trap_ret,
  input logic             gie,
  input logic             gpie,
  input logic             tie,
  input logic             pending,
  input logic             irq_timer,
  input logic             csr_illegal,
  input logic [XLEN-1:0]  csr_rdata,
  input logic             time_tick,
  input logic [CNT_W-1:0] time_cnt,
  input logic [CNT_W-1:0] cycle_cnt
);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_timer |-> $past(pending && tie && gie));

  a_r8_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (pending && tie && gie) |=> irq_timer);

  a_r9_trap_entry: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> (!gie && gpie == $past(gie)));

  a_r10_trap_return: assert property (@(posedge clk) disable iff (rst)
    (trap_ret && !trap_take) |=> (gie == $past(gpie) && gpie));

  a_r5_cycle_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cycle_cnt == $past(cycle_cnt) + 1'b1);

  a_r4_time_hold: assert property (@(posedge clk) disable iff (rst)
    !time_tick |=> $stable(time_cnt));

  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> csr_rdata == '0);
endmodule

bind mcsr_unit mcsr_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .trap_take   (trap_take),
  .trap_ret    (trap_ret),
  .gie         (gie),
  .gpie        (gpie),
  .tie         (tie),
  .pending     (pending),
  .irq_timer   (irq_timer),
  .csr_illegal (csr_illegal),
  .csr_rdata   (csr_rdata),
  .time_tick   (time_tick),
  .time_cnt    (cnt[1]),
  .cycle_cnt   (cnt[0])
);

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        csr_en;
  logic [1:0]  csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        time_tick, instret, trap_take, trap_ret;
  logic [31:0] trap_pc, trap_cause, handler_addr, return_pc;
  logic        irq_timer;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mcsr_unit u0 (
    .clk(clk), .rst(rst), .csr_en(csr_en), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .time_tick(time_tick), .instret(instret),
    .trap_take(trap_take), .trap_pc(trap_pc), .trap_cause(trap_cause),
    .trap_ret(trap_ret), .handler_addr(handler_addr), .return_pc(return_pc),
    .irq_timer(irq_timer)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] r, output logic ill);
    csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0;
    r = csr_rdata;
    ill = csr_illegal;
  endtask

  task automatic test_reset();
    logic [31:0] r; logic ill;
    chk("R1 rdata", csr_rdata, 0);
    chk("R1 illegal", {31'b0, csr_illegal}, 0);
    chk("R1 irq", {31'b0, irq_timer}, 0);
    chk("R1 handler", handler_addr, 0);
    chk("R1 return_pc", return_pc, 0);
    acc(2'd3, 12'h300, 0, r, ill); chk("R1 status", r, 32'h1800);
    acc(2'd3, 12'h800, 0, r, ill); chk("R1 cmp lo", r, 32'hFFFFFFFF);
    acc(2'd3, 12'h801, 0, r, ill); chk("R1 cmp hi", r, 32'hFFFFFFFF);
  endtask

  task automatic test_ops();
    logic [31:0] r; logic ill;
    acc(2'd0, 12'h342, 32'hF0, r, ill);
    acc(2'd1, 12'h342, 32'h0F, r, ill); chk("R2 old value on set", r, 32'hF0);
    acc(2'd2, 12'h342, 32'h3C, r, ill); chk("R3 set result", r, 32'hFF);
    acc(2'd3, 12'h342, 32'hFFFF, r, ill); chk("R3 clear result", r, 32'hC3);
    acc(2'd3, 12'h342, 0, r, ill); chk("R3 read-only op keeps", r, 32'hC3);
    chk("R2 no illegal", {31'b0, ill}, 0);
  endtask

  task automatic test_counters();
    logic [31:0] r1, r2; logic ill;
    acc(2'd3, 12'hC00, 0, r1, ill);
    idle(5);
    acc(2'd3, 12'hC00, 0, r2, ill); chk("R5 cycle step", r2 - r1, 6);
    acc(2'd3, 12'hC80, 0, r2, ill); chk("R5 cycle high", r2, 0);
    acc(2'd0, 12'hC00, 0, r1, ill);
    chk("R12 counter write no illegal", {31'b0, ill}, 0);
    acc(2'd3, 12'hC00, 0, r2, ill); chk("R12 counter write ignored", r2 - r1, 1);
    acc(2'd3, 12'hC01, 0, r1, ill);
    idle(3);
    acc(2'd3, 12'hC01, 0, r2, ill); chk("R4 time holds", r2, r1);
    time_tick = 1'b1; idle(4); time_tick = 1'b0;
    acc(2'd3, 12'hC01, 0, r2, ill); chk("R4 time ticks", r2 - r1, 4);
    acc(2'd3, 12'hC02, 0, r1, ill);
    for (int i = 0; i < 3; i++) begin
      instret = 1'b1; idle(1); instret = 1'b0; idle(1);
    end
    acc(2'd3, 12'hC02, 0, r2, ill); chk("R6 retired count", r2 - r1, 3);
    acc(2'd3, 12'hC82, 0, r2, ill); chk("R6 retired high", r2, 0);
  endtask

  task automatic test_timer();
    logic [31:0] t, r; logic ill;
    acc(2'd3, 12'hC01, 0, t, ill);
    acc(2'd0, 12'h801, 32'h0, r, ill);
    acc(2'd0, 12'h800, t + 3, r, ill);
    acc(2'd0, 12'h304, 32'hFFFFFFFF, r, ill);
    acc(2'd3, 12'h304, 0, r, ill); chk("R13 enable mask", r, 32'h80);
    acc(2'd1, 12'h300, 32'h8, r, ill);
    idle(3);
    chk("R8 irq off before match", {31'b0, irq_timer}, 0);
    acc(2'd3, 12'h344, 0, r, ill); chk("R7 not pending", r, 0);
    time_tick = 1'b1; idle(2); time_tick = 1'b0; idle(3);
    chk("R8 irq off one below", {31'b0, irq_timer}, 0);
    time_tick = 1'b1; idle(1); time_tick = 1'b0; idle(3);
    chk("R8 irq on at match", {31'b0, irq_timer}, 1);
    acc(2'd3, 12'h344, 0, r, ill); chk("R7 pending set", r, 32'h80);
    acc(2'd0, 12'h344, 0, r, ill);
    acc(2'd3, 12'h344, 0, r, ill); chk("R12 pending write ignored", r, 32'h80);
    acc(2'd2, 12'h300, 32'h8, r, ill);
    idle(1);
    chk("R8 irq gated by global", {31'b0, irq_timer}, 0);
    acc(2'd0, 12'h801, 32'hFFFFFFFF, r, ill);
    idle(1);
    acc(2'd3, 12'h344, 0, r, ill); chk("R7 pending clears", r, 0);
  endtask

  task automatic test_trap();
    logic [31:0] r; logic ill;
    acc(2'd0, 12'h305, 32'h80000103, r, ill);
    acc(2'd3, 12'h305, 0, r, ill); chk("R11 vector aligned", r, 32'h80000100);
    chk("R11 handler_addr", handler_addr, 32'h80000100);
    acc(2'd0, 12'h300, 32'hFFFFFFFF, r, ill);
    acc(2'd3, 12'h300, 0, r, ill); chk("R13 status mask", r, 32'h1888);
    trap_take = 1'b1; trap_pc = 32'h10000007; trap_cause = 32'h80000007;
    idle(1); trap_take = 1'b0;
    acc(2'd3, 12'h300, 0, r, ill); chk("R9 status after trap", r, 32'h1880);
    acc(2'd3, 12'h341, 0, r, ill); chk("R9 saved pc", r, 32'h10000004);
    chk("R11 return_pc", return_pc, 32'h10000004);
    acc(2'd3, 12'h342, 0, r, ill); chk("R9 cause", r, 32'h80000007);
    trap_ret = 1'b1; idle(1); trap_ret = 1'b0;
    acc(2'd3, 12'h300, 0, r, ill); chk("R10 status after return", r, 32'h1888);
    acc(2'd0, 12'h300, 32'h0, r, ill);
    trap_ret = 1'b1; idle(1); trap_ret = 1'b0;
    acc(2'd3, 12'h300, 0, r, ill); chk("R10 restore zero", r, 32'h1880);
    trap_take = 1'b1; trap_pc = 32'h00002222; trap_cause = 32'h3;
    acc(2'd0, 12'h341, 32'hDEAD0000, r, ill);
    trap_take = 1'b0;
    acc(2'd3, 12'h341, 0, r, ill); chk("R9 trap beats write", r, 32'h00002220);
    acc(2'd0, 12'h341, 32'h0000ABCF, r, ill);
    chk("R11 return_pc written", return_pc, 32'h0000ABCC);
  endtask

  task automatic test_illegal();
    logic [31:0] r; logic ill;
    acc(2'd3, 12'h123, 0, r, ill);
    chk("R12 unimplemented data", r, 0);
    chk("R12 unimplemented flag", {31'b0, ill}, 1);
    acc(2'd0, 12'hFFF, 32'h5, r, ill);
    chk("R12 unimplemented write flag", {31'b0, ill}, 1);
    acc(2'd3, 12'h342, 0, r, ill);
    chk("R2 flag clears", {31'b0, ill}, 0);
  endtask

  initial begin
    rst = 1'b1; csr_en = 1'b0; csr_op = 2'd3; csr_addr = '0; csr_wdata = '0;
    time_tick = 1'b0; instret = 1'b0; trap_take = 1'b0; trap_ret = 1'b0;
    trap_pc = '0; trap_cause = '0;
    idle(4);
    rst = 1'b0;
    idle(1);
    test_reset();
    test_ops();
    test_counters();
    test_timer();
    test_trap();
    test_illegal();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule